// File: doc/BRIEF.md
# Frame Phase Stuffing Decider

This block belongs to one line-side transmit channel. Once per 6 ms frame it decides whether the outgoing line frame carries no stuff bits or four. A counter running on the general-purpose clock measures how far the line transmit frame start lags the PCM transmit frame start, in whole clock periods. That phase is compared with two programmable limits: a lower stuffing limit and an upper error limit. A phase below the stuffing limit adds nothing. A phase at or above it adds four stuff bits, whose values come from a 4-bit programmable register. A phase at or above the error limit also adds four bits, and it sets a sticky error flag that stays set until software clears it with a strobe.

The two limits and the stuff-value register are sampled only on the cycle when the line frame start closes a measurement. The decision they produce is held until the next measurement closes. A one-cycle `dec_vld` pulse tells the frame assembler that a new decision is ready. Every pin is a plain control or status signal. Nothing streams through the block, so it has no valid/ready handshake and applies no back-pressure: the assembler must take the decision while the next frame is being built.

Top module: `stf_decider`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `stuff_en`, `stuff_bits`, `dec_vld` and `stuff_err` are all 0.
- R2: The measured phase is the number of rising clock edges from the edge that samples `pcm_sof` to the edge that samples `line_sof`. When both pulses are sampled on the same edge, the phase is 0. The decision appears on the outputs right after the edge that samples `line_sof`, and `dec_vld` is high for exactly that one cycle.
- R3: When the phase is below `thr_stuff`, the new decision has `stuff_en` = 0 and `stuff_bits` = 0.
- R4: When the phase is at least `thr_stuff` and below `thr_err`, `stuff_en` = 1 and `stuff_bits` equals `stuff_val` as sampled on the capturing edge. Bit i of `stuff_bits` is bit i of `stuff_val`. The error flag is not set.
- R5: When the phase is at least `thr_err`, `stuff_en` = 1, `stuff_bits` equals the sampled `stuff_val`, and `stuff_err` becomes 1.
- R6: `stuff_err` stays at 1 until an edge samples `err_clr` high. If a new error and `err_clr` fall on the same edge, the flag stays 1.
- R7: The phase counter stops at 2^CNT_W-1 and does not wrap. A longer gap therefore measures as 2^CNT_W-1.
- R8: `thr_stuff`, `thr_err` and `stuff_val` affect the outputs only through their values on the capturing edge. Changing them at any other time has no effect on the outputs.
- R9: A `line_sof` pulse with no measurement open produces no `dec_vld` and leaves every output unchanged.
- R10: A `pcm_sof` pulse while a measurement is open restarts the measurement from that pulse.
- R11: `stuff_en` and `stuff_bits` keep their values between captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | General-purpose clock that quantizes the phase |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| pcm_sof | input | 1 | One-cycle pulse at the PCM transmit frame start |
| line_sof | input | 1 | One-cycle pulse at the line transmit frame start |
| thr_stuff | input | THR_W (16) | Phase at or above which four stuff bits are inserted |
| thr_err | input | THR_W (16) | Phase at or above which the stuffing error is raised |
| stuff_val | input | STUFF_N (4) | Values to place in the inserted stuff bits |
| err_clr | input | 1 | Read-clear strobe for `stuff_err` |
| stuff_en | output | 1 | 1 = insert four stuff bits in the coming frame, 0 = insert none |
| stuff_bits | output | STUFF_N (4) | Stuff bit values for the coming frame, 0 when none are inserted |
| dec_vld | output | 1 | One-cycle pulse when a new decision has been latched |
| stuff_err | output | 1 | Sticky transmit stuffing error |

## Verification
The assertions assume the following about the inputs:
- `pcm_sof` and `line_sof` are synchronous to `clk`.
- Each pulse is high for one cycle at a time.
- `err_clr` is a clean strobe.

The bench meets these assumptions by driving every input on the falling edge, and it asserts each frame pulse for exactly one cycle. A line pulse either closes an open measurement or, in the R9 case, deliberately arrives with none open. Between captures, the limits and stuff values are held at deliberately wrong values, so any early sampling would change a decision.

// File: rtl/stf_pkg.sv
package stf_pkg;

  // Result of comparing one measured phase against the two limits
  typedef enum logic [1:0] {
    PH_EARLY = 2'd0,  // below stuffing limit: no stuff bits
    PH_STUFF = 2'd1,  // stuff four bits, in range
    PH_ERROR = 2'd2   // stuff four bits, phase out of range
  } ph_class_e;

  function automatic logic class_stuffs(ph_class_e c);
    return (c == PH_STUFF) || (c == PH_ERROR);
  endfunction

endpackage

// File: rtl/stf_phase_ctr.sv
module stf_phase_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pcm_sof,
  input  logic             line_sof,
  output logic             cap,
  output logic [CNT_W-1:0] phase
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // A capture closes an open window, or a window opened and closed at once
  assign cap   = line_sof && (run_q || pcm_sof);
  assign phase = pcm_sof ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (pcm_sof && !line_sof) begin
      cnt_q <= CNT_ONE;
      run_q <= 1'b1;
    end else if (line_sof) begin
      run_q <= 1'b0;
    end else if (run_q && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == CNT_MAX && !pcm_sof && !line_sof) |=> (cnt_q == CNT_MAX)); // R7

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_sof && !line_sof) |=> (run_q && cnt_q == CNT_ONE)); // R10

  AST_IDLE_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !pcm_sof) |-> !cap); // R9

endmodule

// File: rtl/stf_classify.sv
module stf_classify
  import stf_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int THR_W = 16
) (
  input  logic [CNT_W-1:0] phase,
  input  logic [THR_W-1:0] thr_stuff,
  input  logic [THR_W-1:0] thr_err,
  output ph_class_e        cls
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] ph_x, ts_x, te_x;

  assign ph_x = CMP_W'(phase);
  assign ts_x = CMP_W'(thr_stuff);
  assign te_x = CMP_W'(thr_err);

  // The error limit is checked first, so it wins even if the limits are misordered
  always_comb begin
    if (ph_x >= te_x)      cls = PH_ERROR;
    else if (ph_x >= ts_x) cls = PH_STUFF;
    else                   cls = PH_EARLY;
  end

endmodule

// File: rtl/stf_dec_reg.sv
module stf_dec_reg
  import stf_pkg::*;
#(
  parameter int STUFF_N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  ph_class_e          cls,
  input  logic [STUFF_N-1:0] stuff_val,
  input  logic               err_clr,
  output logic               stuff_en,
  output logic [STUFF_N-1:0] stuff_bits,
  output logic               dec_vld,
  output logic               stuff_err
);

  logic               en_q;
  logic [STUFF_N-1:0] bits_q;
  logic               vld_q;
  logic               err_q;
  logic               do_stuff;

  assign do_stuff = class_stuffs(cls);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= cap;
      if (cap) en_q <= do_stuff;
      // A new error wins over a clear on the same edge
      if (cap && cls == PH_ERROR) err_q <= 1'b1;
      else if (err_clr)           err_q <= 1'b0;
    end
  end

  // Each stuff bit is loaded from its own value bit, and forced to 0 when nothing is stuffed
  for (genvar i = 0; i < STUFF_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)   bits_q[i] <= 1'b0;
      else if (cap) bits_q[i] <= stuff_val[i] & do_stuff;
    end
  end

  assign stuff_en   = en_q;
  assign stuff_bits = bits_q;
  assign dec_vld    = vld_q;
  assign stuff_err  = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q); // R6

  AST_ERR_WITH_STUFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (en_q && vld_q)); // R5

  AST_NO_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (bits_q == '0)); // R3

  AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> ($stable(en_q) && $stable(bits_q))); // R11

endmodule

// File: rtl/stf_decider.sv
module stf_decider
  import stf_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int THR_W   = 16,
  parameter int STUFF_N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pcm_sof,
  input  logic               line_sof,
  input  logic [THR_W-1:0]   thr_stuff,
  input  logic [THR_W-1:0]   thr_err,
  input  logic [STUFF_N-1:0] stuff_val,
  input  logic               err_clr,
  output logic               stuff_en,
  output logic [STUFF_N-1:0] stuff_bits,
  output logic               dec_vld,
  output logic               stuff_err
);

  logic             cap;
  logic [CNT_W-1:0] phase;
  ph_class_e        cls;

  stf_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pcm_sof  (pcm_sof),
    .line_sof (line_sof),
    .cap      (cap),
    .phase    (phase)
  );

  stf_classify #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cls (
    .phase     (phase),
    .thr_stuff (thr_stuff),
    .thr_err   (thr_err),
    .cls       (cls)
  );

  stf_dec_reg #(.STUFF_N(STUFF_N)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap        (cap),
    .cls        (cls),
    .stuff_val  (stuff_val),
    .err_clr    (err_clr),
    .stuff_en   (stuff_en),
    .stuff_bits (stuff_bits),
    .dec_vld    (dec_vld),
    .stuff_err  (stuff_err)
  );

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld || $past(line_sof)); // R2

endmodule

// File: tb/test_stf_decider.sv
module test_stf_decider;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int MAXV       = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pcm_sof = 1'b0, line_sof = 1'b0, err_clr = 1'b0;
  logic [15:0] thr_stuff = '0, thr_err = '0;
  logic [3:0]  stuff_val = '0;
  logic        stuff_en, dec_vld, stuff_err;
  logic [3:0]  stuff_bits;

  int checks = 0, errors = 0;
  bit done = 0;
  bit err_model = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stf_decider #(.CNT_W(CNT_W), .THR_W(16), .STUFF_N(4)) i_stf_decider (
    .clk(clk), .rst_n(rst_n), .pcm_sof(pcm_sof), .line_sof(line_sof),
    .thr_stuff(thr_stuff), .thr_err(thr_err), .stuff_val(stuff_val),
    .err_clr(err_clr), .stuff_en(stuff_en), .stuff_bits(stuff_bits),
    .dec_vld(dec_vld), .stuff_err(stuff_err)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Open a window, close it k edges later, and check the new decision.
  // The limits and values hold wrong values except on the capture cycle (R8).
  task automatic measure(int k, int ta, int tc, logic [3:0] sv, bit clr);
    int  ph;
    bit  st, er;
    @(negedge clk);
    pcm_sof   = 1'b1;
    thr_stuff = 16'(~ta);
    thr_err   = 16'(~tc);
    stuff_val = ~sv;
    if (k == 0) begin
      line_sof = 1'b1; thr_stuff = 16'(ta); thr_err = 16'(tc);
      stuff_val = sv; err_clr = clr;
    end
    @(negedge clk);
    pcm_sof = 1'b0; line_sof = 1'b0; err_clr = 1'b0;
    thr_stuff = 16'(~ta); thr_err = 16'(~tc); stuff_val = ~sv;
    if (k > 0) begin
      repeat (k-1) @(negedge clk);
      line_sof = 1'b1; thr_stuff = 16'(ta); thr_err = 16'(tc);
      stuff_val = sv; err_clr = clr;
      @(negedge clk);
      line_sof = 1'b0; err_clr = 1'b0;
      thr_stuff = 16'(~ta); thr_err = 16'(~tc); stuff_val = ~sv;
    end
    ph = (k > MAXV) ? MAXV : k;                    // R7 saturation
    st = (ph >= ta) || (ph >= tc);
    er = (ph >= tc);
    err_model = er || (err_model && !clr);
    check("R2 dec_vld pulse", dec_vld, 1);
    check(st ? (er ? "R5 stuff_en" : "R4 stuff_en") : "R3 stuff_en", stuff_en, st);
    check(st ? "R4 stuff_bits" : "R3 stuff_bits", stuff_bits, st ? sv : 0);
    check(er ? "R5 stuff_err" : "R6 stuff_err", stuff_err, err_model);
    @(negedge clk);
    check("R2 dec_vld single", dec_vld, 0);
    check("R8 stuff_en after limit change", stuff_en, st);
    check("R11 stuff_bits held", stuff_bits, st ? sv : 0);
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    err_model = 0;
    check("R6 cleared", stuff_err, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int tas[3] = '{0, 5, 17};
    int tcs[3] = '{10, 40, 63};
    bit e0, s0;
    logic [3:0] b0;
    repeat (3) @(negedge clk);
    check("R1 stuff_en", stuff_en, 0);
    check("R1 stuff_bits", stuff_bits, 0);
    check("R1 dec_vld", dec_vld, 0);
    check("R1 stuff_err", stuff_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {stuff_en, stuff_bits, dec_vld, stuff_err}, 0);

    // Sweep phase 0..MAXV+7 over a grid of limits
    foreach (tas[a]) foreach (tcs[c]) begin
      for (int k = 0; k <= MAXV + 7; k++) begin
        measure(k, tas[a], tcs[c], 4'(k) ^ 4'hA, 1'b0);
        if (err_model) clear_err();
      end
    end

    // R6: an error on the same edge as a clear keeps the flag set
    measure(50, 5, 20, 4'h6, 1'b1);
    check("R6 set wins", stuff_err, 1);
    // A clear strobe together with an in-range capture does clear the flag
    measure(8, 5, 20, 4'h3, 1'b1);
    check("R6 clear with capture", stuff_err, 0);

    // R9: a line pulse with no open window is ignored
    measure(12, 5, 20, 4'h9, 1'b0);
    s0 = stuff_en; b0 = stuff_bits; e0 = stuff_err;
    @(negedge clk); line_sof = 1'b1; thr_stuff = 16'd0; thr_err = 16'd0;
    @(negedge clk); line_sof = 1'b0;
    check("R9 no dec_vld", dec_vld, 0);
    check("R9 stuff_en", stuff_en, s0);
    check("R9 stuff_bits", stuff_bits, b0);
    check("R9 stuff_err", stuff_err, e0);

    // R10: a second pcm pulse restarts the window (measure issues the second pulse)
    @(negedge clk); pcm_sof = 1'b1;
    @(negedge clk); pcm_sof = 1'b0;
    repeat (6) @(negedge clk);
    measure(3, 5, 40, 4'hF, 1'b0);
    check("R10 restart no stuff", stuff_en, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule